// File: doc/BRIEF.md
# Floating-Point Status and Control Register

This block holds the 32-bit status and control word of a floating-point unit and carries out the instructions that move data into and out of it. It supports five operations. A nibble-masked write takes its data from the low half of a 64-bit source operand. An immediate write puts a 4-bit value into one nibble field. A single-bit set and a single-bit clear each take a big-endian bit index. A field copy moves one status nibble into a 32-bit condition register that the block owns. Each operation is started by a one-cycle `op_valid` strobe and completes on that clock edge.

Exception causes raised by arithmetic units arrive on a sticky OR-in port and are merged every cycle. The two summary bits, the invalid summary (bit 29) and the enabled-exception summary (bit 30), are never written directly. They are recomputed only after an immediate write or after a sticky merge. The block also drives three outputs without a register: a 4-bit summary for condition field 1, the rounding mode, and a 64-bit read image.

Top module: `fp_status_ctl`

## Requirements
- R1: Reset clears the status word and the condition register to zero. While `op_valid` is low and `exc_set` is zero, both registers hold their value.
- R2: Operation code 0 is the masked write. Mask bit k (7..0) selects status bits 4k+3..4k, which take the value of `src_operand` at the same positions. Bits 30 and 29 are never written by this operation. When `exc_set` is zero, the summary bits keep their value.
- R3: Operation codes 2 and 3 set and clear one bit. Index n addresses status bit 31-n. Indices 1 and 2 are ignored, and no summary is recomputed.
- R4: Operation code 1 is the immediate write. It places `imm_val` into field `fld_sel`, where field f covers bits 31-4f..28-4f. Bits 30 and 29 are not written from `imm_val`. Both summaries are recomputed afterwards.
- R5: When recomputed, the invalid summary (bit 29) is 1 exactly when any of status bits 24..19 or 10..8 is set.
- R6: When recomputed, the enabled-exception summary (bit 30) is the OR of the bitwise AND of bits 29..25 with bits 7..3. The invalid summary used here is the freshly recomputed one.
- R7: Operation code 4 copies status field `fld_sel` into condition-register field `cr_fld`, where field d covers bits 31-4d..28-4d. The copied value is the one from before the clear. In the source field it then clears only the bits under mask 0x9FF80700 (bits 31, 28..19 and 10..8). Nothing is recomputed.
- R8: `exc_set` bits other than 30 and 29 are ORed into the result of the current operation. Whenever any such bit is set, both summaries are recomputed.
- R9: `cr1_sum` equals status bits 31..28, and `rnd_mode` equals bits 1..0 (0 nearest, 1 toward zero, 2 toward +inf, 3 toward -inf).
- R10: `read_data` carries the status word in bits 31..0. Its upper half is 0xFFF80000, or all ones while `legacy_mode` is high.
- R11: Operation codes 5 to 7 change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 3 | Operation select |
| src_operand | input | 64 | Source for the masked write (low half used) |
| field_mask | input | 8 | Nibble mask for the masked write |
| imm_val | input | 4 | Value for the immediate write |
| fld_sel | input | 3 | Status field for the immediate write and the copy |
| bit_idx | input | 5 | Big-endian bit index for set and clear |
| cr_fld | input | 3 | Destination condition-register field |
| exc_set | input | 32 | Sticky exception bits to OR in |
| legacy_mode | input | 1 | Selects the all-ones upper read half |
| status_q | output | 32 | Status and control word |
| cond_reg | output | 32 | Condition register |
| cr1_sum | output | 4 | Summary nibble for condition field 1 |
| rnd_mode | output | 2 | Rounding mode |
| read_data | output | 64 | Read image of the status word |

## Verification
The hardest state to reach is a summary bit that disagrees with its causes. A masked write, a bit clear or a field copy can remove invalid causes without touching bit 29. Only a later immediate write or sticky merge brings the two back into agreement. The random stimulus uses sticky input on only about a quarter of cycles, and it mixes masked writes with full-mask sources. Stale summaries therefore build up and are later repaired. Directed steps also pair a full-mask write of ones with clears of indices 1 and 2, and then run a copy from field 0.

// File: rtl/fp_status_ctl_pkg.sv
package fp_status_ctl_pkg;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = 8;
  localparam int REG_W      = FIELD_W * NUM_FIELDS;
  localparam int IDX_W      = $clog2(REG_W);
  localparam int FSEL_W     = $clog2(NUM_FIELDS);

  localparam int EN_SUM_BIT  = 30;
  localparam int INV_SUM_BIT = 29;

  localparam logic [REG_W-1:0] SUMMARY_MASK  = 32'h6000_0000;
  localparam logic [REG_W-1:0] INV_CAUSES    = 32'h01F8_0700;
  localparam logic [REG_W-1:0] STICKY_CLEAR  = 32'h9FF8_0700;

  typedef enum logic [2:0] {
    OP_FMASK = 3'd0,
    OP_FIMM  = 3'd1,
    OP_BSET  = 3'd2,
    OP_BCLR  = 3'd3,
    OP_TOCR  = 3'd4
  } fpsc_op_e;

  function automatic logic [REG_W-1:0] field_bits(input logic [FSEL_W-1:0] f);
    field_bits = {{FIELD_W{1'b1}}, {(REG_W-FIELD_W){1'b0}}} >> (FIELD_W * int'(f));
  endfunction

  function automatic logic invalid_summary(input logic [REG_W-1:0] v);
    invalid_summary = |(v & INV_CAUSES);
  endfunction

  function automatic logic enabled_summary(input logic [REG_W-1:0] v);
    enabled_summary = |(v[29:25] & v[7:3]);
  endfunction

  function automatic logic [REG_W-1:0] resummarize(input logic [REG_W-1:0] v);
    logic [REG_W-1:0] t;
    t = v;
    t[INV_SUM_BIT] = invalid_summary(t);
    t[EN_SUM_BIT]  = enabled_summary(t);
    resummarize = t;
  endfunction
endpackage

// File: rtl/fp_status_write.sv
module fp_status_write
  import fp_status_ctl_pkg::*;
(
  input  logic [REG_W-1:0]      cur_q,
  input  logic                  op_valid,
  input  logic [2:0]            op_code,
  input  logic [REG_W-1:0]      src_lo,
  input  logic [NUM_FIELDS-1:0] field_mask,
  input  logic [FIELD_W-1:0]    imm_val,
  input  logic [FSEL_W-1:0]     fld_sel,
  input  logic [IDX_W-1:0]      bit_idx,
  input  logic [REG_W-1:0]      exc_set,
  output logic [REG_W-1:0]      nxt_d,
  output logic                  recalc_evt,
  output logic                  bit_op_blocked
);
  logic [REG_W-1:0] mask_wide;
  logic [REG_W-1:0] imm_wide;
  logic [REG_W-1:0] sel_field;
  logic [REG_W-1:0] one_hot_bit;
  logic [REG_W-1:0] sticky_bits;
  logic [REG_W-1:0] op_result;
  logic             imm_recalc;
  fpsc_op_e         op_e;

  genvar k;
  generate
    for (k = 0; k < NUM_FIELDS; k++) begin : g_expand
      assign mask_wide[k*FIELD_W +: FIELD_W] = {FIELD_W{field_mask[k]}};
      assign imm_wide[k*FIELD_W +: FIELD_W]  = imm_val;
    end
  endgenerate

  assign op_e           = fpsc_op_e'(op_code);
  assign sel_field      = field_bits(fld_sel);
  assign one_hot_bit    = {1'b1, {(REG_W-1){1'b0}}} >> bit_idx;
  assign bit_op_blocked = (bit_idx == IDX_W'(1)) || (bit_idx == IDX_W'(2));
  assign sticky_bits    = exc_set & ~SUMMARY_MASK;

  always_comb begin
    op_result  = cur_q;
    imm_recalc = 1'b0;
    if (op_valid) begin
      case (op_e)
        OP_FMASK: begin
          op_result = (cur_q & ~(mask_wide & ~SUMMARY_MASK)) |
                      (src_lo & mask_wide & ~SUMMARY_MASK);
        end
        OP_FIMM: begin
          op_result  = (cur_q & ~(sel_field & ~SUMMARY_MASK)) |
                       (imm_wide & sel_field & ~SUMMARY_MASK);
          imm_recalc = 1'b1;
        end
        OP_BSET: begin
          if (!bit_op_blocked) op_result = cur_q | one_hot_bit;
        end
        OP_BCLR: begin
          if (!bit_op_blocked) op_result = cur_q & ~one_hot_bit;
        end
        OP_TOCR: begin
          op_result = cur_q & ~(sel_field & STICKY_CLEAR);
        end
        default: op_result = cur_q;
      endcase
    end
  end

  assign recalc_evt = imm_recalc || (sticky_bits != '0);
  assign nxt_d = recalc_evt ? resummarize(op_result | sticky_bits)
                            : (op_result | sticky_bits);
endmodule

// File: rtl/fp_status_crcopy.sv
module fp_status_crcopy
  import fp_status_ctl_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  copy_en,
  input  logic [REG_W-1:0]      cur_q,
  input  logic [FSEL_W-1:0]     src_fld,
  input  logic [FSEL_W-1:0]     dst_fld,
  output logic [REG_W-1:0]      cr_q
);
  logic [FIELD_W-1:0] src_nib;
  logic [NUM_FIELDS-1:0] dst_hit;

  assign src_nib = cur_q[REG_W-1 - FIELD_W*int'(src_fld) -: FIELD_W];

  genvar d;
  generate
    for (d = 0; d < NUM_FIELDS; d++) begin : g_crf
      assign dst_hit[d] = copy_en && (dst_fld == FSEL_W'(d));
      always_ff @(posedge clk) begin
        if (!rst_n)
          cr_q[REG_W-1 - FIELD_W*d -: FIELD_W] <= '0;
        else if (dst_hit[d])
          cr_q[REG_W-1 - FIELD_W*d -: FIELD_W] <= src_nib;
      end
    end
  endgenerate
endmodule

// File: rtl/fp_status_read.sv
module fp_status_read
  import fp_status_ctl_pkg::*;
#(
  parameter logic [REG_W-1:0] HI_NORMAL = 32'hFFF8_0000,
  parameter logic [REG_W-1:0] HI_LEGACY = 32'hFFFF_FFFF
) (
  input  logic [REG_W-1:0]   cur_q,
  input  logic               legacy_mode,
  output logic [2*REG_W-1:0] read_data,
  output logic [FIELD_W-1:0] cr1_sum,
  output logic [1:0]         rnd_mode
);
  assign read_data = {(legacy_mode ? HI_LEGACY : HI_NORMAL), cur_q};
  assign cr1_sum   = cur_q[REG_W-1 -: FIELD_W];
  assign rnd_mode  = cur_q[1:0];
endmodule

// File: rtl/fp_status_ctl.sv
module fp_status_ctl
  import fp_status_ctl_pkg::*;
#(
  parameter logic [31:0] READ_HI_NORMAL = 32'hFFF8_0000,
  parameter logic [31:0] READ_HI_LEGACY = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        op_valid,
  input  logic [2:0]  op_code,
  input  logic [63:0] src_operand,
  input  logic [7:0]  field_mask,
  input  logic [3:0]  imm_val,
  input  logic [2:0]  fld_sel,
  input  logic [4:0]  bit_idx,
  input  logic [2:0]  cr_fld,
  input  logic [31:0] exc_set,
  input  logic        legacy_mode,
  output logic [31:0] status_q,
  output logic [31:0] cond_reg,
  output logic [3:0]  cr1_sum,
  output logic [1:0]  rnd_mode,
  output logic [63:0] read_data
);
  logic [REG_W-1:0] nxt_d;
  logic             recalc_evt;
  logic             bit_op_blocked;
  logic             copy_evt;

  assign copy_evt = op_valid && (op_code == OP_TOCR);

  fp_status_write u_write (
    .cur_q          (status_q),
    .op_valid       (op_valid),
    .op_code        (op_code),
    .src_lo         (src_operand[REG_W-1:0]),
    .field_mask     (field_mask),
    .imm_val        (imm_val),
    .fld_sel        (fld_sel),
    .bit_idx        (bit_idx),
    .exc_set        (exc_set),
    .nxt_d          (nxt_d),
    .recalc_evt     (recalc_evt),
    .bit_op_blocked (bit_op_blocked)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt_d;
  end

  fp_status_crcopy u_crcopy (
    .clk     (clk),
    .rst_n   (rst_n),
    .copy_en (copy_evt),
    .cur_q   (status_q),
    .src_fld (fld_sel),
    .dst_fld (cr_fld),
    .cr_q    (cond_reg)
  );

  fp_status_read #(
    .HI_NORMAL (READ_HI_NORMAL),
    .HI_LEGACY (READ_HI_LEGACY)
  ) u_read (
    .cur_q       (status_q),
    .legacy_mode (legacy_mode),
    .read_data   (read_data),
    .cr1_sum     (cr1_sum),
    .rnd_mode    (rnd_mode)
  );
endmodule

// File: rtl/fp_status_ctl_chk.sv
module fp_status_ctl_chk
  import fp_status_ctl_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [2:0]  op_code,
  input logic [2:0]  fld_sel,
  input logic [31:0] exc_set,
  input logic [31:0] status_q,
  input logic [31:0] cond_reg,
  input logic        recalc_evt
);
  logic [31:0] sticky_eff;
  logic [31:0] copy_clr;
  assign sticky_eff = exc_set & ~SUMMARY_MASK;
  assign copy_clr   = STICKY_CLEAR & (32'hF000_0000 >> {fld_sel, 2'b00});

  // R1
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_valid && exc_set == '0) |=> ($stable(status_q) && $stable(cond_reg)));

  // R2
  summary_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && (op_code == OP_FMASK || op_code == OP_BSET || op_code == OP_BCLR)
     && sticky_eff == '0) |=> (status_q[30:29] == $past(status_q[30:29])));

  // R5
  inv_recalc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recalc_evt |=> (status_q[29] == |(status_q & INV_CAUSES)));

  // R6
  en_recalc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_FIMM) |=> (status_q[30] == |(status_q[29:25] & status_q[7:3])));

  // R7
  copy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OP_TOCR && sticky_eff == '0) |=> ((status_q & $past(copy_clr)) == '0));

  // R8
  sticky_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_eff != '0) |=> ((status_q & $past(sticky_eff)) == $past(sticky_eff)));
endmodule

bind fp_status_ctl fp_status_ctl_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .fld_sel    (fld_sel),
  .exc_set    (exc_set),
  .status_q   (status_q),
  .cond_reg   (cond_reg),
  .recalc_evt (recalc_evt)
);

// File: tb/test_fp_status_ctl.sv
module test_fp_status_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [2:0]  op_code = '0;
  logic [63:0] src_operand = '0;
  logic [7:0]  field_mask = '0;
  logic [3:0]  imm_val = '0;
  logic [2:0]  fld_sel = '0;
  logic [4:0]  bit_idx = '0;
  logic [2:0]  cr_fld = '0;
  logic [31:0] exc_set = '0;
  logic        legacy_mode = 1'b0;
  logic [31:0] status_q, cond_reg;
  logic [3:0]  cr1_sum;
  logic [1:0]  rnd_mode;
  logic [63:0] read_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  logic [31:0] exp_st = '0;
  logic [31:0] exp_cr = '0;

  always #5 clk = ~clk;

  fp_status_ctl i_fp_status_ctl (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic bit in_clear_set(input int p);
    return (p == 31) || (p <= 28 && p >= 19) || (p <= 10 && p >= 8);
  endfunction

  function automatic void model(input logic v, input logic [2:0] op, input logic [31:0] src,
      input logic [7:0] m, input logic [3:0] im, input int f, input int ix, input int d,
      input logic [31:0] st, inout logic [31:0] s, inout logic [31:0] c);
    logic [31:0] o;
    bit rec;
    logic inv, en;
    o = s; rec = 0;
    if (v) begin
      case (op)
        3'd0: for (int k = 0; k < 8; k++)
                for (int b = 0; b < 4; b++)
                  if (m[k] && (4*k+b) != 29 && (4*k+b) != 30) o[4*k+b] = src[4*k+b];
        3'd1: begin
          for (int b = 0; b < 4; b++) begin
            int p = 28 - 4*f + b;
            if (p != 29 && p != 30) o[p] = im[b];
          end
          rec = 1;
        end
        3'd2: if (ix != 1 && ix != 2) o[31-ix] = 1'b1;
        3'd3: if (ix != 1 && ix != 2) o[31-ix] = 1'b0;
        3'd4: for (int b = 0; b < 4; b++) begin
                int p = 28 - 4*f + b;
                c[28 - 4*d + b] = s[p];
                if (in_clear_set(p)) o[p] = 1'b0;
              end
        default: ;
      endcase
    end
    for (int p = 0; p < 32; p++)
      if (p != 29 && p != 30 && st[p]) begin o[p] = 1'b1; rec = 1; end
    if (rec) begin
      inv = 1'b0;
      for (int p = 19; p <= 24; p++) inv |= o[p];
      for (int p = 8; p <= 10; p++) inv |= o[p];
      o[29] = inv;
      en = 1'b0;
      for (int k = 0; k < 5; k++) en |= o[25+k] & o[3+k];
      o[30] = en;
    end
    s = o;
  endfunction

  task automatic step(input string req, input logic v, input logic [2:0] op, input logic [63:0] src,
      input logic [7:0] m, input logic [3:0] im, input logic [2:0] f, input logic [4:0] ix,
      input logic [2:0] d, input logic [31:0] st);
    op_valid = v; op_code = op; src_operand = src; field_mask = m; imm_val = im;
    fld_sel = f; bit_idx = ix; cr_fld = d; exc_set = st;
    model(v, op, src[31:0], m, im, int'(f), int'(ix), int'(d), st, exp_st, exp_cr);
    @(posedge clk);
    @(negedge clk);
    op_valid = 1'b0; exc_set = '0;
    chk({req, " status"}, {32'd0, status_q}, {32'd0, exp_st});
    chk({req, " cr"}, {32'd0, cond_reg}, {32'd0, exp_cr});
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset status", {32'd0, status_q}, 64'd0);
    chk("R1 reset cr", {32'd0, cond_reg}, 64'd0);
    // R10 read image normal and legacy
    chk("R10 read normal", read_data, 64'hFFF80000_00000000);
    legacy_mode = 1'b1; #1;
    chk("R10 read legacy", read_data, 64'hFFFFFFFF_00000000);
    legacy_mode = 1'b0;
    // R2 full mask of ones leaves summaries clear
    step("R2 full mask", 1, 3'd0, 64'hFFFFFFFF_FFFFFFFF, 8'hFF, 0, 0, 0, 0, 0);
    chk("R2 value", {32'd0, status_q}, 64'h9FFFFFFF);
    // R3 protected indices ignored, normal index acts
    step("R3 set idx1", 1, 3'd2, 0, 0, 0, 0, 5'd1, 0, 0);
    step("R3 clr idx2", 1, 3'd3, 0, 0, 0, 0, 5'd2, 0, 0);
    step("R3 clr idx0", 1, 3'd3, 0, 0, 0, 0, 5'd0, 0, 0);
    chk("R3 value", {32'd0, status_q}, 64'h1FFFFFFF);
    // R9 rounding and cr1 outputs
    chk("R9 rnd", {62'd0, rnd_mode}, 64'd3);
    chk("R9 cr1", {60'd0, cr1_sum}, {60'd0, status_q[31:28]});
    // R4 R5 R6 immediate write recomputes summaries
    step("R4 imm f7", 1, 3'd1, 0, 0, 4'h0, 3'd7, 0, 0, 0);
    chk("R5 R6 value", {32'd0, status_q}, 64'h7FFFFFF0);
    // R7 copy field 0 into cr field 5 then clear sticky bits of field 0
    step("R7 copy f0", 1, 3'd4, 0, 0, 0, 3'd0, 0, 3'd5, 0);
    chk("R7 cr field", {32'd0, cond_reg}, 64'h00000700);
    // R11 reserved code and low valid
    step("R11 code6", 1, 3'd6, 64'hFFFF, 8'hFF, 4'hF, 0, 0, 0, 0);
    step("R1 idle", 0, 3'd0, 64'h0, 8'hFF, 0, 0, 0, 0, 0);
    // R8 sticky merge with summary recompute
    step("R8 sticky", 1, 3'd3, 0, 0, 0, 0, 5'd31, 0, 32'h6000_0100);
    for (int i = 0; i < 600; i++) begin
      logic [31:0] st;
      st = (($urandom % 4) == 0) ? ($urandom & $urandom & $urandom) : 32'd0;
      step("R2 R3 R4 R7 R8 random", (($urandom % 8) != 0), 3'($urandom % 8),
           {$urandom, $urandom}, 8'($urandom), 4'($urandom), 3'($urandom),
           5'($urandom), 3'($urandom), st);
      if (i % 50 == 0) begin
        legacy_mode = 1'($urandom); #1;
        chk("R10 random read", read_data,
            {(legacy_mode ? 32'hFFFFFFFF : 32'hFFF80000), exp_st});
        chk("R9 random outs", {58'd0, cr1_sum, rnd_mode}, {58'd0, exp_st[31:28], exp_st[1:0]});
      end
    end
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule